// File: doc/BRIEF.md
# Sub-element result bit packer

This block gathers a stream of narrow results, each either one bit or four bits wide, and packs them into destination elements of 64, 32, 16 or 8 bits. A result arrives on each cycle where the input valid flag is high. A two-bit group-size field sets how many results make up a group: 1, 2, 4 or 8. A two-bit element-width code sets the size of the destination element.

When the packed results fill an element, the block emits that element one cycle later. Each emitted element carries a running element index and a byte write strobe that covers the element width. With one-bit results, a whole group always lands in the low bits of a single element. With four-bit results, a group that is too wide for a narrow element carries on into the next element. A last-input flag flushes a group that is only partly filled.

The surrounding datapath holds the mode, group-size and width fields steady for the length of a stream. It consumes the emitted elements in the same cycle they are presented.

Top module: `result_packer`

## Requirements
- R1: The group-size field `grp_sel` selects the group size: 00 = 1 result, 01 = 2, 10 = 4, 11 = 8. One-bit results emit one element per completed group.
- R2: Within an element, result j occupies bits j*w through j*w+w-1, where w is 1 when `res_wide`=0 and 4 when `res_wide`=1. In one-bit mode only `in_data[0]` is taken.
- R3: Every output data bit above the packed results is zero.
- R4: With four-bit results and width code 10 (16-bit element), an element holds at most four results. A group of 8 is emitted as two elements: results 0-3 in the first, results 4-7 in the second.
- R5: With four-bit results and width code 11 (8-bit element), every two results complete one element.
- R6: With four-bit results and width code 01 (32-bit element) or 00 (64-bit element), a group of eight results is emitted as a single element.
- R7: A valid input with `in_last` high completes the element in progress, even if it is only partly filled.
- R8: `out_valid` pulses for exactly one cycle. The pulse comes in the cycle after the clock edge that accepts the input completing an element.
- R9: After reset, `out_valid` is low, the index of the first emitted element is 0, and each later element's index is one more than the previous one.
- R10: Cycles with `in_valid` low emit nothing and leave the partly packed element unchanged.
- R11: While `out_valid` is high, `out_strb` is a byte mask set by the width code: 00 = 0xFF, 01 = 0x0F, 10 = 0x03, 11 = 0x01. It is zero while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_wide | input | 1 | 0 = one-bit results, 1 = four-bit results |
| grp_sel | input | 2 | Group-size code |
| elem_w | input | 2 | Destination element-width code |
| in_valid | input | 1 | A result is present this cycle |
| in_data | input | 4 | Result value (bit 0 only in one-bit mode) |
| in_last | input | 1 | Final result of the stream |
| out_valid | output | 1 | Completed element present |
| out_data | output | 64 | Packed element, zero above the packed results |
| out_index | output | IDX_W | Running element index |
| out_strb | output | 8 | Byte write strobe of the element |

## Verification
The bench drives one-bit streams with every group size and both wide and narrow elements. It also drives four-bit streams in 16-, 8-, 32- and 64-bit elements, so that an element filled by a whole group can be told apart from a group that spills into the elements that follow. Each result in a stream has a distinct value, so a wrong slot order or a lost result changes the packed word. Idle gaps inside a group show that held state is not disturbed. Streams ended early by the last flag show that flushing works. A reset in the middle of a stream shows that the index restarts.

// File: rtl/rpk_pkg.sv
package rpk_pkg;
    // Full destination register width; the width codes divide it by 1, 2, 4, 8.
    localparam int unsigned DATA_W = 64;
    localparam int unsigned STRB_W = DATA_W / 8;

    typedef enum logic [1:0] {
        EW_64 = 2'd0,
        EW_32 = 2'd1,
        EW_16 = 2'd2,
        EW_8  = 2'd3
    } elem_w_e;

    function automatic logic [STRB_W-1:0] strobe_of(input logic [1:0] code);
        logic [STRB_W-1:0] full;
        full = '1;
        return full >> (STRB_W - (STRB_W >> code));
    endfunction
endpackage

// File: rtl/rpk_capacity.sv
// Number of results that complete one destination element.
module rpk_capacity #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned WIDE_W = 4,
    localparam int unsigned CNT_W = $clog2(SLOTS) + 1
) (
    input  logic             res_wide,
    input  logic [1:0]       grp_sel,
    input  logic [1:0]       elem_w,
    output logic [CNT_W-1:0] cap
);
    import rpk_pkg::*;
    localparam int unsigned WSH = $clog2(WIDE_W);

    logic [7:0] elem_bits;
    logic [7:0] room;
    logic [7:0] group;

    always_comb begin
        elem_bits = 8'(DATA_W >> elem_w);
        room      = res_wide ? (elem_bits >> WSH) : elem_bits;
        group     = 8'(1) << grp_sel;
        cap       = (room < group) ? CNT_W'(room) : CNT_W'(group);
    end
endmodule

// File: rtl/rpk_place.sv
// Moves one result into its slot position within an element.
module rpk_place #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned WIDE_W = 4,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned DATA_W = rpk_pkg::DATA_W
) (
    input  logic              res_wide,
    input  logic [SLOT_W-1:0] slot,
    input  logic [WIDE_W-1:0] data,
    output logic [DATA_W-1:0] placed
);
    logic [SLOTS*WIDE_W-1:0] wide_f;
    logic [SLOTS-1:0]        narrow_f;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign wide_f[s*WIDE_W +: WIDE_W] = (slot == SLOT_W'(s)) ? data : '0;
        assign narrow_f[s]                = (slot == SLOT_W'(s)) & data[0];
    end

    assign placed = res_wide ? DATA_W'(wide_f) : DATA_W'(narrow_f);
endmodule

// File: rtl/result_packer.sv
module result_packer #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned WIDE_W = 4,
    parameter int unsigned IDX_W  = 16,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned CNT_W  = SLOT_W + 1,
    localparam int unsigned DATA_W = rpk_pkg::DATA_W,
    localparam int unsigned STRB_W = rpk_pkg::STRB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_wide,
    input  logic [1:0]        grp_sel,
    input  logic [1:0]        elem_w,
    input  logic              in_valid,
    input  logic [WIDE_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [IDX_W-1:0]  out_index,
    output logic [STRB_W-1:0] out_strb
);
    import rpk_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [CNT_W-1:0]  fill;
        logic [IDX_W-1:0]  idx;
        logic              ov;
        logic [DATA_W-1:0] od;
        logic [IDX_W-1:0]  oi;
        logic [STRB_W-1:0] os;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]  cap;
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] acc_next;
    logic [CNT_W-1:0]  fill_next;
    logic              done;

    rpk_capacity #(.SLOTS(SLOTS), .WIDE_W(WIDE_W)) u_cap (
        .res_wide (res_wide),
        .grp_sel  (grp_sel),
        .elem_w   (elem_w),
        .cap      (cap)
    );

    rpk_place #(.SLOTS(SLOTS), .WIDE_W(WIDE_W)) u_place (
        .res_wide (res_wide),
        .slot     (st_q.fill[SLOT_W-1:0]),
        .data     (in_data),
        .placed   (placed)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ov   = 1'b0;
        st_d.os   = '0;
        acc_next  = st_q.acc | placed;
        fill_next = st_q.fill + CNT_W'(1);
        done      = (fill_next >= cap) || in_last;
        if (in_valid) begin
            if (done) begin
                st_d.ov   = 1'b1;
                st_d.od   = acc_next;
                st_d.oi   = st_q.idx;
                st_d.os   = strobe_of(elem_w);
                st_d.idx  = st_q.idx + IDX_W'(1);
                st_d.acc  = '0;
                st_d.fill = '0;
            end else begin
                st_d.acc  = acc_next;
                st_d.fill = fill_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_index = st_q.oi;
    assign out_strb  = st_q.os;
endmodule

// File: rtl/rpk_checker.sv
module rpk_checker #(
    parameter int unsigned IDX_W  = 16,
    localparam int unsigned DATA_W = rpk_pkg::DATA_W,
    localparam int unsigned STRB_W = rpk_pkg::STRB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic [1:0]        elem_w,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [IDX_W-1:0]  out_index,
    input logic [STRB_W-1:0] out_strb
);
    logic [IDX_W-1:0]  seen_q;
    logic [1:0]        ew_prev_q;
    logic [DATA_W-1:0] above;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q    <= '0;
            ew_prev_q <= 2'd0;
        end else begin
            ew_prev_q <= elem_w;
            if (out_valid) seen_q <= seen_q + IDX_W'(1);
        end
    end

    assign above = out_data >> (DATA_W >> ew_prev_q);

    AST_INDEX_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_index == seen_q); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> above == '0); // R3
    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R10
    AST_LAST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> out_valid); // R7
    AST_STRB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_strb == '0); // R11
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_valid)) |-> 1'b0); // R8
endmodule

bind result_packer rpk_checker #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .elem_w    (elem_w),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_index (out_index),
    .out_strb  (out_strb)
);

// File: tb/result_packer_test.sv
module result_packer_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 16;
    localparam int NVEC = 41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_wide = 1'b0;
    logic [1:0]  grp_sel = 2'd0;
    logic [1:0]  elem_w = 2'd0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_data = 4'd0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [IDX_W-1:0] out_index;
    logic [7:0]  out_strb;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    result_packer #(.IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .res_wide(res_wide), .grp_sel(grp_sel),
        .elem_w(elem_w), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_data(out_data), .out_index(out_index),
        .out_strb(out_strb)
    );

    // row: {wide, grp, ew, data, last, exp_valid, exp_data[31:0], exp_idx[7:0]}
    localparam logic [50:0] VEC [NVEC] = '{
        // R1 R2: one-bit, group of 1, 64-bit element
        {1'b0, 2'd0, 2'd0, 4'h1, 1'b0, 1'b1, 32'h1, 8'd0},
        {1'b0, 2'd0, 2'd0, 4'h0, 1'b0, 1'b1, 32'h0, 8'd1},
        // R1 R2: one-bit, group of 4, upper input bits ignored
        {1'b0, 2'd2, 2'd0, 4'hF, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd2, 2'd0, 4'hE, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd2, 2'd0, 4'h1, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd2, 2'd0, 4'h3, 1'b0, 1'b1, 32'hD, 8'd2},
        // R1 R2: one-bit, group of 8 in an 8-bit element
        {1'b0, 2'd3, 2'd3, 4'h1, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd3, 4'h1, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd3, 4'h0, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd3, 4'h0, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd3, 4'h1, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd3, 4'h0, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd3, 4'h1, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd3, 4'h0, 1'b0, 1'b1, 32'h53, 8'd3},
        // R4: four-bit, group of 8 into 16-bit elements spills into two
        {1'b1, 2'd3, 2'd2, 4'h1, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd2, 4'h2, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd2, 4'h3, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd2, 4'h4, 1'b0, 1'b1, 32'h4321, 8'd4},
        {1'b1, 2'd3, 2'd2, 4'h5, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd2, 4'h6, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd2, 4'h7, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd2, 4'h8, 1'b0, 1'b1, 32'h8765, 8'd5},
        // R4: four-bit, group of 2 in a 16-bit element
        {1'b1, 2'd1, 2'd2, 4'hA, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd1, 2'd2, 4'hB, 1'b0, 1'b1, 32'hBA, 8'd6},
        // R5: four-bit, group of 4 in 8-bit elements
        {1'b1, 2'd2, 2'd3, 4'h1, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd2, 2'd3, 4'h2, 1'b0, 1'b1, 32'h21, 8'd7},
        {1'b1, 2'd2, 2'd3, 4'h3, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd2, 2'd3, 4'h4, 1'b0, 1'b1, 32'h43, 8'd8},
        // R6: four-bit, group of 8 in one 32-bit element
        {1'b1, 2'd3, 2'd1, 4'h9, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd1, 4'h8, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd1, 4'h7, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd1, 4'h6, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd1, 4'h5, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd1, 4'h4, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd1, 4'h3, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd1, 4'h2, 1'b0, 1'b1, 32'h23456789, 8'd9},
        // R7: one-bit partial group flushed by last
        {1'b0, 2'd3, 2'd0, 4'h1, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd0, 4'h0, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b0, 2'd3, 2'd0, 4'h1, 1'b1, 1'b1, 32'h5, 8'd10},
        // R6 R7: four-bit in a 64-bit element, flushed after two
        {1'b1, 2'd3, 2'd0, 4'hF, 1'b0, 1'b0, 32'h0, 8'd0},
        {1'b1, 2'd3, 2'd0, 4'hE, 1'b1, 1'b1, 32'hEF, 8'd11}
    };

    function automatic logic [7:0] exp_strb(input logic [1:0] code);
        case (code)
            2'd0:    return 8'hFF;
            2'd1:    return 8'h0F;
            2'd2:    return 8'h03;
            default: return 8'h01;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Outputs sampled after the negedge that follows the capturing posedge.
    task automatic drive(input logic v, input logic [3:0] d, input logic l);
        in_valid = v;
        in_data  = d;
        in_last  = l;
        @(negedge clk);
    endtask

    task automatic check_emit(input string req, input logic [63:0] ed,
                              input int ei, input logic [1:0] ew);
        check(out_valid == 1'b1, req, "valid", 64'(out_valid), 64'd1);
        check(out_data == ed, req, "data", out_data, ed);
        check(out_index == IDX_W'(ei), req, "index", 64'(out_index), 64'(ei));
        check(out_strb == exp_strb(ew), "R11", "strobe", 64'(out_strb), 64'(exp_strb(ew)));
    endtask

    task automatic check_quiet(input string req);
        check(out_valid == 1'b0, req, "valid", 64'(out_valid), 64'd0);
        check(out_strb == 8'h00, "R11", "idle strobe", 64'(out_strb), 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check_quiet("R9");
        check(out_index == '0, "R9", "reset index", 64'(out_index), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            res_wide = VEC[i][50];
            grp_sel  = VEC[i][49:48];
            elem_w   = VEC[i][47:46];
            drive(1'b1, VEC[i][45:42], VEC[i][41]);
            if (VEC[i][40])
                check_emit("R2", 64'(VEC[i][39:8]), int'(VEC[i][7:0]), VEC[i][47:46]);
            else
                check_quiet("R8");
        end
        drive(1'b0, 4'h0, 1'b0);
        // R8: pulse lasts one cycle
        check_quiet("R8");

        // R10: idle gaps inside a one-bit group of 4
        res_wide = 1'b0; grp_sel = 2'd2; elem_w = 2'd0;
        drive(1'b1, 4'h1, 1'b0);
        check_quiet("R10");
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 4'hF, 1'b1);
            check_quiet("R10");
        end
        drive(1'b1, 4'h0, 1'b0);
        drive(1'b1, 4'h0, 1'b0);
        drive(1'b1, 4'h1, 1'b0);
        check_emit("R10", 64'h9, 12, 2'd0);
        drive(1'b0, 4'h0, 1'b0);

        // R3: four-bit group of 8 in a 64-bit element, all ones
        res_wide = 1'b1; grp_sel = 2'd3; elem_w = 2'd0;
        for (int k = 0; k < 7; k++) drive(1'b1, 4'hF, 1'b0);
        drive(1'b1, 4'hF, 1'b0);
        check_emit("R3", 64'hFFFF_FFFF, 13, 2'd0);

        // R9: reset mid-stream restarts the index
        res_wide = 1'b0; grp_sel = 2'd3;
        drive(1'b1, 4'h1, 1'b0);
        drive(1'b1, 4'h1, 1'b0);
        rst_n = 1'b0;
        drive(1'b0, 4'h0, 1'b0);
        check_quiet("R9");
        rst_n = 1'b1;
        grp_sel = 2'd0; elem_w = 2'd3;
        drive(1'b1, 4'h1, 1'b0);
        check_emit("R9", 64'h1, 0, 2'd3);
        drive(1'b1, 4'h0, 1'b0);
        check_emit("R9", 64'h0, 1, 2'd3);
        drive(1'b0, 4'h0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule